// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block conditions up to six asynchronous interrupt pins for a processor. Each pin has a mask bit, a write-one clear strobe and three mode bits: level-select, polarity and any-edge. Together these select low level, high level, rising edge, falling edge or both edges. Every pin input passes through a two-flop synchroniser. In level mode the pin's request follows the synchronised input. In edge mode a detected transition sets a sticky pending bit, and that bit stays set until software clears it.

Two 32-bit configuration words hold the settings, four pins per word. Pins 0 to 3 live in word 0 and pins 4 and 5 in word 1, each at slot `pin mod 4`. Each request output is gated by its pin's mask. It can drive a dedicated processor interrupt line or feed one status bit of a downstream interrupt controller.

Top module: `exti_unit`

## Requirements
- R1: Word `pin/4` holds the pin's settings at slot `s = pin mod 4`. The clear strobe is bit `s`, mask is bit `4+s`, any-edge is bit `8+s`, polarity (1 = high/rising) is bit `12+s` and level-select is bit `16+s`. A write stores the mask and the three mode bits. Clear bits and bits 31:20 always read back as 0, and the read data follows the address combinationally.
- R2: Slots that belong to no pin (slots 2 and 3 of word 1 when six pins are built) ignore writes and read back as 0. Writing all ones to word 1 reads back as 0x00033330.
- R3: When a pin's mask bit is 0, its request output is 0.
- R4: With level-select 1, a masked-in pin's request equals (synchronised input == polarity), and any-edge is ignored. A pin change driven before clock edge k shows on the request after edge k+1.
- R5: With level-select 0 and any-edge 0, a rising transition (polarity 1) or a falling transition (polarity 0) sets the pin's pending bit. The request shows it after edge k+2 for a change driven before edge k, and it stays high after the pin returns.
- R6: With level-select 0 and any-edge 1, both rising and falling transitions set the pending bit.
- R7: Writing 1 to a pin's clear bit removes its pending bit at that write's clock edge.
- R8: If a clear and a new edge fall on the same clock edge, the pending bit stays set.
- R9: The pending bit latches edges while the pin is masked. The request appears as soon as the mask write lands.
- R10: Reset sets every configuration bit, pending bit and synchroniser flop to 0, so all requests and read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | NUM_PINS | Raw external interrupt pins |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 1 | Configuration word select |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Read data of the selected word |
| irqReq | output | NUM_PINS | Per-pin interrupt request |

## Verification
Mask and read data change in the same cycle as the write edge. A level request follows a pin change two edges after it is driven. An edge request follows three edges after, and a clear drops it at the write edge. The bench keeps a history queue of sampled pin values and sets of mode and pending bits. It advances these at every rising edge and compares both outputs 2 ns later. Directed checks wait exactly the counted number of edges and also probe one edge early to confirm the delay.

// File: rtl/exti_pkg.sv
package exti_pkg;
  localparam int MAX_PINS  = 6;
  localparam int SLOTS     = 4;
  localparam int REG_COUNT = (MAX_PINS + SLOTS - 1) / SLOTS;
  localparam int ADDR_W    = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam int DATA_W    = 32;

  localparam int CLR_LSB   = 0;
  localparam int MASK_LSB  = CLR_LSB + SLOTS;
  localparam int BOTH_LSB  = MASK_LSB + SLOTS;
  localparam int SENSE_LSB = BOTH_LSB + SLOTS;
  localparam int LEVEL_LSB = SENSE_LSB + SLOTS;
  localparam int USED_BITS = LEVEL_LSB + SLOTS;

  // Stored settings of one pin
  typedef struct packed {
    logic maskEn;
    logic bothEdge;
    logic senseHigh;
    logic levelMode;
  } pinMode_t;

  // Strobes and settings from the register file to the pin datapath
  typedef struct packed {
    logic [MAX_PINS-1:0] clrPulse;
    logic [MAX_PINS-1:0] maskEn;
    logic [MAX_PINS-1:0] bothEdge;
    logic [MAX_PINS-1:0] senseHigh;
    logic [MAX_PINS-1:0] levelMode;
  } pinCtrl_t;
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/exti_regs.sv
module exti_regs
  import exti_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output pinCtrl_t          ctrlBus
);
  logic [MAX_PINS-1:0] clrVec, maskVec, bothVec, senseVec, levelVec;
  logic                wrUnused;

  assign wrUnused = ^wrData[DATA_W-1:USED_BITS];

  for (genvar p = 0; p < MAX_PINS; p++) begin : gPin
    if (p < NUM_PINS) begin : gLive
      localparam int REG_IDX = p / SLOTS;
      localparam int SLOT    = p % SLOTS;
      logic     hit;
      pinMode_t modeQ;

      assign hit = wrEn && (addr == ADDR_W'(REG_IDX));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          modeQ <= '0;
        end else if (hit) begin
          modeQ.maskEn    <= wrData[MASK_LSB  + SLOT];
          modeQ.bothEdge  <= wrData[BOTH_LSB  + SLOT];
          modeQ.senseHigh <= wrData[SENSE_LSB + SLOT];
          modeQ.levelMode <= wrData[LEVEL_LSB + SLOT];
        end
      end

      assign clrVec[p]   = hit & wrData[CLR_LSB + SLOT];
      assign maskVec[p]  = modeQ.maskEn;
      assign bothVec[p]  = modeQ.bothEdge;
      assign senseVec[p] = modeQ.senseHigh;
      assign levelVec[p] = modeQ.levelMode;
    end else begin : gAbsent
      assign clrVec[p]   = 1'b0;
      assign maskVec[p]  = 1'b0;
      assign bothVec[p]  = 1'b0;
      assign senseVec[p] = 1'b0;
      assign levelVec[p] = 1'b0;
    end
  end

  always_comb begin
    ctrlBus.clrPulse  = clrVec;
    ctrlBus.maskEn    = maskVec;
    ctrlBus.bothEdge  = bothVec;
    ctrlBus.senseHigh = senseVec;
    ctrlBus.levelMode = levelVec;
  end

  // Read mux: clear bits and unused slots stay zero
  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr == ADDR_W'(p / SLOTS)) begin
        rdData[MASK_LSB  + (p % SLOTS)] = maskVec[p];
        rdData[BOTH_LSB  + (p % SLOTS)] = bothVec[p];
        rdData[SENSE_LSB + (p % SLOTS)] = senseVec[p];
        rdData[LEVEL_LSB + (p % SLOTS)] = levelVec[p];
      end
    end
  end
endmodule

// File: rtl/exti_pins.sv
module exti_pins
  import exti_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] extPin,
  input  pinCtrl_t            ctrlBus,
  output logic [NUM_PINS-1:0] irqReq
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    logic syncQ, prevQ, pendQ, edgeHit, levelHit;

    exti_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk (clk),
      .rstN(rstN),
      .din (extPin[p]),
      .dout(syncQ)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevQ <= 1'b0;
      else       prevQ <= syncQ;
    end

    always_comb begin
      if (ctrlBus.bothEdge[p])       edgeHit = syncQ ^ prevQ;
      else if (ctrlBus.senseHigh[p]) edgeHit = syncQ & ~prevQ;
      else                           edgeHit = ~syncQ & prevQ;
    end

    // New edge takes priority over a simultaneous clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     pendQ <= 1'b0;
      else if (!ctrlBus.levelMode[p] && edgeHit)     pendQ <= 1'b1;
      else if (ctrlBus.clrPulse[p])                  pendQ <= 1'b0;
    end

    assign levelHit  = (syncQ == ctrlBus.senseHigh[p]);
    assign irqReq[p] = ctrlBus.maskEn[p] &
                       (ctrlBus.levelMode[p] ? levelHit : pendQ);
  end
endmodule

// File: rtl/exti_unit.sv
module exti_unit #(
  parameter int NUM_PINS = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PINS-1:0]          extPin,
  input  logic                         cfgWrEn,
  input  logic [exti_pkg::ADDR_W-1:0]  cfgAddr,
  input  logic [exti_pkg::DATA_W-1:0]  cfgWrData,
  output logic [exti_pkg::DATA_W-1:0]  cfgRdData,
  output logic [NUM_PINS-1:0]          irqReq
);
  exti_pkg::pinCtrl_t ctrlBus;

  exti_regs #(.NUM_PINS(NUM_PINS)) uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (cfgWrEn),
    .addr   (cfgAddr),
    .wrData (cfgWrData),
    .rdData (cfgRdData),
    .ctrlBus(ctrlBus)
  );

  exti_pins #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(2)) uPins (
    .clk    (clk),
    .rstN   (rstN),
    .extPin (extPin),
    .ctrlBus(ctrlBus),
    .irqReq (irqReq)
  );
endmodule

// File: rtl/exti_unit_chk.sv
module exti_unit_chk
  import exti_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] extPin,
  input logic [NUM_PINS-1:0] irqReq,
  input logic [DATA_W-1:0]   cfgRdData,
  input pinCtrl_t            ctrlBus
);
  logic [1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assert_clear_reads_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[SLOTS-1:0] == '0);

  assert_spare_bits_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[DATA_W-1:USED_BITS] == '0);

  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
      !ctrlBus.maskEn[p] |-> !irqReq[p]);

    assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt >= 2'd2 && ctrlBus.levelMode[p] && ctrlBus.maskEn[p]) |->
        (irqReq[p] == ($past(extPin[p], 2) == ctrlBus.senseHigh[p])));
  end
endmodule

bind exti_unit exti_unit_chk #(.NUM_PINS(NUM_PINS)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .extPin   (extPin),
  .irqReq   (irqReq),
  .cfgRdData(cfgRdData),
  .ctrlBus  (ctrlBus)
);

// File: tb/exti_unit_test.sv
`timescale 1ns/1ps
module exti_unit_test;
  import exti_pkg::*;
  localparam int NP = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN;
  logic [NP-1:0]     extPin;
  logic              cfgWrEn;
  logic [ADDR_W-1:0] cfgAddr;
  logic [31:0]       cfgWrData;
  logic [31:0]       cfgRdData;
  logic [NP-1:0]     irqReq;

  exti_unit #(.NUM_PINS(NP)) uut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .irqReq(irqReq)
  );

  int checks = 0;
  int failures = 0;

  // Reference model state
  bit mMask[NP], mBoth[NP], mSense[NP], mLevel[NP], mPend[NP];
  logic [NP-1:0] pinHist[$] = '{6'b0, 6'b0, 6'b0};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(int r);
    logic [31:0] v = '0;
    for (int p = 0; p < NP; p++) begin
      if (p / 4 == r) begin
        v[4 + p % 4]  = mMask[p];
        v[8 + p % 4]  = mBoth[p];
        v[12 + p % 4] = mSense[p];
        v[16 + p % 4] = mLevel[p];
      end
    end
    return v;
  endfunction

  function automatic bit expReq(int p);
    bit s = pinHist[1][p];
    if (!mMask[p]) return 1'b0;
    if (mLevel[p]) return s == mSense[p];
    return mPend[p];
  endfunction

  // Model advance on every edge, compare 2 ns later
  always @(posedge clk) begin : modelStep
    logic [NP-1:0] s2, pv;
    bit edgeSeen, clrSeen;
    if (!rstN) begin
      for (int p = 0; p < NP; p++) begin
        mMask[p] = 0; mBoth[p] = 0; mSense[p] = 0; mLevel[p] = 0; mPend[p] = 0;
      end
      pinHist = '{6'b0, 6'b0, 6'b0};
    end else begin
      s2 = pinHist[1];
      pv = pinHist[2];
      for (int p = 0; p < NP; p++) begin
        if (mBoth[p])       edgeSeen = s2[p] != pv[p];
        else if (mSense[p]) edgeSeen = s2[p] && !pv[p];
        else                edgeSeen = !s2[p] && pv[p];
        clrSeen = cfgWrEn && (int'(cfgAddr) == p / 4) && cfgWrData[p % 4];
        if (!mLevel[p] && edgeSeen) mPend[p] = 1;
        else if (clrSeen)           mPend[p] = 0;
      end
      if (cfgWrEn) begin
        for (int p = 0; p < NP; p++) begin
          if (int'(cfgAddr) == p / 4) begin
            mMask[p]  = cfgWrData[4 + p % 4];
            mBoth[p]  = cfgWrData[8 + p % 4];
            mSense[p] = cfgWrData[12 + p % 4];
            mLevel[p] = cfgWrData[16 + p % 4];
          end
        end
      end
      pinHist.push_front(extPin);
      void'(pinHist.pop_back());
    end
    #2;
    check(rstN ? "R1" : "R10", cfgRdData, expRead(int'(cfgAddr)), "read data");
    for (int p = 0; p < NP; p++) begin
      string tag;
      if (!rstN)          tag = "R10";
      else if (!mMask[p]) tag = "R3";
      else if (mLevel[p]) tag = "R4";
      else if (mBoth[p])  tag = "R6";
      else                tag = "R5";
      check(tag, 32'(irqReq[p]), 32'(expReq(p)), $sformatf("request pin %0d", p));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic drivePin(int p, bit v);
    @(negedge clk);
    extPin[p] = v;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgAddr   = ADDR_W'(a);
    cfgWrData = d;
    @(posedge clk);
    #1 cfgWrEn = 1'b0;
    #2;
  endtask

  task automatic expectReq(int p, bit v, string tag);
    check(tag, 32'(irqReq[p]), 32'(v), $sformatf("directed pin %0d", p));
  endtask

  initial begin : watchdog
    #(8ns * 200000);
    failures++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stimulus
    logic [31:0] cfg0, cfg1;
    rstN = 1'b0; extPin = '0; cfgWrEn = 1'b0; cfgAddr = '0; cfgWrData = '0;
    tick(3);
    check("R10", 32'(irqReq), 32'd0, "reset requests");
    check("R10", cfgRdData, 32'd0, "reset read word 0");
    @(negedge clk); rstN = 1'b1;
    tick(2);

    // R4 level high on pin 0, with the two-edge delay
    cfg0 = (1 << 4) | (1 << 12) | (1 << 16);
    wr(0, cfg0);
    expectReq(0, 0, "R4");
    drivePin(0, 1);
    tick(1); expectReq(0, 0, "R4");
    tick(1); expectReq(0, 1, "R4");
    drivePin(0, 0);
    tick(2); expectReq(0, 0, "R4");

    // R4 level low on pin 3, any-edge bit ignored
    cfg0 |= (1 << 7) | (1 << 11) | (1 << 19);
    wr(0, cfg0);
    expectReq(3, 1, "R4");
    drivePin(3, 1);
    tick(2); expectReq(3, 0, "R4");

    // R5 rising edge on pin 1, then R7 clear
    cfg0 |= (1 << 5) | (1 << 13);
    wr(0, cfg0);
    drivePin(1, 1);
    tick(2); expectReq(1, 0, "R5");
    tick(1); expectReq(1, 1, "R5");
    drivePin(1, 0);
    tick(4); expectReq(1, 1, "R5");
    wr(0, cfg0 | 32'h2);
    expectReq(1, 0, "R7");

    // R6 both edges on pin 4
    cfg1 = (1 << 4) | (1 << 8);
    wr(1, cfg1);
    drivePin(4, 1);
    tick(3); expectReq(4, 1, "R6");
    wr(1, cfg1 | 32'h1);
    expectReq(4, 0, "R7");
    drivePin(4, 0);
    tick(3); expectReq(4, 1, "R6");
    wr(1, cfg1 | 32'h1);

    // R5 falling edge on pin 5, then R8 clear racing a new edge
    cfg1 |= (1 << 5);
    wr(1, cfg1);
    drivePin(5, 1);
    tick(4); expectReq(5, 0, "R5");
    drivePin(5, 0);
    tick(4); expectReq(5, 1, "R5");
    drivePin(5, 1);
    tick(4); expectReq(5, 1, "R5");
    drivePin(5, 0);
    @(posedge clk);
    @(posedge clk);
    wr(1, cfg1 | 32'h2);
    expectReq(5, 1, "R8");
    wr(1, cfg1 | 32'h2);
    expectReq(5, 0, "R7");

    // R9 edge latched while masked on pin 2
    cfg0 |= (1 << 14);
    wr(0, cfg0);
    drivePin(2, 1);
    tick(4); expectReq(2, 0, "R9");
    wr(0, cfg0 | (1 << 6));
    expectReq(2, 1, "R9");

    // R2 spare slots of word 1
    wr(1, 32'hFFFF_FFFF);
    check("R2", cfgRdData, 32'h0003_3330, "word 1 after all-ones write");

    // Random phase, model compared on every edge
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++)
        if ($urandom % 8 == 0) extPin[p] = ~extPin[p];
      cfgAddr = ADDR_W'($urandom % 2);
      if ($urandom % 16 == 0) begin
        cfgWrEn = 1'b1;
        cfgWrData = $urandom;
      end else begin
        cfgWrEn = 1'b0;
      end
    end
    @(negedge clk); cfgWrEn = 1'b0;

    // R10 reset mid-run with pins high
    extPin = '1;
    rstN = 1'b0;
    tick(2);
    check("R10", 32'(irqReq), 32'd0, "requests in reset");
    check("R10", cfgRdData, 32'd0, "read data in reset");
    @(negedge clk); rstN = 1'b1;
    tick(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule